// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer

This block is the control sequencer of a multicycle 32-bit processor. Each instruction passes through a short series of states. The block reads the 6-bit opcode held in the instruction register and steps through those states. In each state it drives the select and enable lines that steer the datapath: program counter load, instruction register load, memory read and write, register-file write, ALU operand and operation selects, and the next-PC source. The datapath itself is outside this block: registers, memory, ALU and multiplexers.

The outputs are Moore outputs, decoded from the current state alone. The opcode affects only which state comes next. The supported classes are register-register arithmetic, word load, word store, branch-if-equal, jump, and jump-with-link. Jump-with-link finishes in a dedicated state. That state loads the jump target into the PC and, in the same cycle, writes the return address (PC+4) into register 31. To make this possible, the destination-register select and the write-back data select are both three-way, with 2-bit codes. Every port is a plain control pin: no data stream crosses this block, so it has no valid/ready handshake.

Top module: `mc_ctrl_fsm`

## Requirements
- R1: A synchronous active-high `rst` puts the sequencer in state 0 (fetch) on the next rising edge, from any state. `state_o` reports the state number.
- R2: In fetch (0), the block asserts `mem_rd`, `ir_we` and `pc_we`, and drives `alu_a_sel`=0, `alu_b_sel`=01, `alu_op_sel`=00, `pc_src_sel`=00 and `addr_sel`=0. Fetch is always followed by decode (1).
- R3: In decode (1), the block drives `alu_a_sel`=0, `alu_b_sel`=11 and `alu_op_sel`=00, with no write enables. The next state depends on the opcode: 000000 (register op) goes to 6, 100011 (load) and 101011 (store) go to 2, 000100 (branch) goes to 8, 000010 (jump) goes to 9, and 000011 (jump-with-link) goes to 10.
- R4: A load runs through states 0, 1, 2, 3, 4 and returns to 0, five cycles in all. State 2 drives `alu_a_sel`=1 and `alu_b_sel`=10. State 3 drives `mem_rd` with `addr_sel`=1. State 4 drives `rf_we` with `dst_sel`=00 and `wb_sel`=01.
- R5: A store runs through states 0, 1, 2, 5 and returns to 0. State 5 drives `mem_wr` with `addr_sel`=1.
- R6: A register op runs through states 0, 1, 6, 7 and returns to 0. State 6 drives `alu_a_sel`=1, `alu_b_sel`=00 and `alu_op_sel`=10. State 7 drives `rf_we` with `dst_sel`=01 and `wb_sel`=00.
- R7: A branch runs through states 0, 1, 8 and returns to 0. State 8 drives `pc_we_cond`, `pc_src_sel`=01, `alu_op_sel`=01, `alu_a_sel`=1 and `alu_b_sel`=00.
- R8: A jump runs through states 0, 1, 9 and returns to 0. State 9 drives `pc_we` with `pc_src_sel`=10.
- R9: A jump-with-link takes exactly 3 cycles: states 0, 1, 10, then back to 0. In state 10 the block asserts `pc_we` and `rf_we` together, with `pc_src_sel`=10, `dst_sel`=10 and `wb_sel`=10.
- R10: Any opcode not listed in R3 sends decode straight back to fetch.
- R11: Every write enable (`pc_we`, `pc_we_cond`, `ir_we`, `mem_wr`, `rf_we`) is low in each state that does not use it. `mem_wr` and `rf_we` are never high together.
- R12: The destination select codes are 00 for rt, 01 for rd and 10 for register 31. The write-back select codes are 00 for ALU result, 01 for memory data and 10 for PC+4. In states that do not write the register file, both selects are 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 6 | Opcode field of the instruction register |
| state_o | output | 4 | Current state number |
| pc_we | output | 1 | Unconditional PC load |
| pc_we_cond | output | 1 | PC load qualified by ALU zero |
| addr_sel | output | 1 | Memory address: 0 = PC, 1 = ALU result register |
| mem_rd | output | 1 | Memory read |
| mem_wr | output | 1 | Memory write |
| ir_we | output | 1 | Instruction register load |
| wb_sel | output | 2 | Register write data: 00 ALU result, 01 memory, 10 PC+4 |
| pc_src_sel | output | 2 | Next PC: 00 ALU, 01 ALU result register, 10 jump target |
| alu_op_sel | output | 2 | ALU operation class: 00 add, 01 subtract, 10 function field |
| alu_a_sel | output | 1 | ALU A: 0 = PC, 1 = register A |
| alu_b_sel | output | 2 | ALU B: 00 reg B, 01 constant 4, 10 immediate, 11 shifted immediate |
| rf_we | output | 1 | Register-file write |
| dst_sel | output | 2 | Destination register: 00 rt, 01 rd, 10 register 31 |

## Verification
Two functions share a cycle in the jump-with-link state: the PC load of the jump target and the link write of PC+4 into register 31. No other state combines a PC load with a register write. The bench provokes this case by issuing jump-with-link after a load and after an unknown opcode, and also twice in a row. In every cycle it compares both enables and all three selects against its reference model, and it times the instruction to confirm it takes exactly three cycles.

// File: rtl/mcc_pkg.sv
package mcc_pkg;

  localparam int ST_W = 4;

  typedef enum logic [ST_W-1:0] {
    S_FETCH  = 4'd0,
    S_DECODE = 4'd1,
    S_MADDR  = 4'd2,
    S_MREAD  = 4'd3,
    S_LDWB   = 4'd4,
    S_MWRITE = 4'd5,
    S_REXEC  = 4'd6,
    S_RWB    = 4'd7,
    S_BRANCH = 4'd8,
    S_JUMP   = 4'd9,
    S_LINK   = 4'd10
  } st_e;

  typedef struct packed {
    logic       pc_we;
    logic       pc_we_cond;
    logic       addr_sel;
    logic       mem_rd;
    logic       mem_wr;
    logic       ir_we;
    logic [1:0] wb_sel;
    logic [1:0] pc_src_sel;
    logic [1:0] alu_op_sel;
    logic       alu_a_sel;
    logic [1:0] alu_b_sel;
    logic       rf_we;
    logic [1:0] dst_sel;
  } ctrl_t;

  // selector codes
  localparam logic [1:0] DST_RT  = 2'b00;
  localparam logic [1:0] DST_RD  = 2'b01;
  localparam logic [1:0] DST_R31 = 2'b10;
  localparam logic [1:0] WB_ALU  = 2'b00;
  localparam logic [1:0] WB_MEM  = 2'b01;
  localparam logic [1:0] WB_LINK = 2'b10;

endpackage

// File: rtl/mcc_state_reg.sv
module mcc_state_reg
  import mcc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  st_e  nxt,
  output st_e  cur
);
  always_ff @(posedge clk) begin
    if (rst) cur <= S_FETCH;
    else     cur <= nxt;
  end
endmodule

// File: rtl/mcc_next_state.sv
module mcc_next_state
  import mcc_pkg::*;
#(
  parameter int               OP_W  = 6,
  parameter logic [OP_W-1:0]  OPC_R = 6'b000000,
  parameter logic [OP_W-1:0]  OPC_L = 6'b100011,
  parameter logic [OP_W-1:0]  OPC_S = 6'b101011,
  parameter logic [OP_W-1:0]  OPC_B = 6'b000100,
  parameter logic [OP_W-1:0]  OPC_J = 6'b000010,
  parameter logic [OP_W-1:0]  OPC_JL = 6'b000011
)(
  input  st_e             cur,
  input  logic [OP_W-1:0] opcode,
  output st_e             nxt
);
  st_e dispatch;

  // decode-time dispatch on opcode; unknown codes fall back to fetch
  always_comb begin
    if      (opcode == OPC_R)                      dispatch = S_REXEC;
    else if (opcode == OPC_L || opcode == OPC_S)   dispatch = S_MADDR;
    else if (opcode == OPC_B)                      dispatch = S_BRANCH;
    else if (opcode == OPC_J)                      dispatch = S_JUMP;
    else if (opcode == OPC_JL)                     dispatch = S_LINK;
    else                                           dispatch = S_FETCH;
  end

  always_comb begin
    case (cur)
      S_FETCH:  nxt = S_DECODE;
      S_DECODE: nxt = dispatch;
      S_MADDR: begin
        if      (opcode == OPC_L) nxt = S_MREAD;
        else if (opcode == OPC_S) nxt = S_MWRITE;
        else                      nxt = S_FETCH;
      end
      S_MREAD:  nxt = S_LDWB;
      S_REXEC:  nxt = S_RWB;
      default:  nxt = S_FETCH;
    endcase
  end
endmodule

// File: rtl/mcc_out_decode.sv
module mcc_out_decode
  import mcc_pkg::*;
(
  input  st_e   cur,
  output ctrl_t ctl
);
  always_comb begin
    ctl = '0;
    case (cur)
      S_FETCH: begin
        ctl.mem_rd     = 1'b1;
        ctl.ir_we      = 1'b1;
        ctl.pc_we      = 1'b1;
        ctl.alu_b_sel  = 2'b01;
      end
      S_DECODE: begin
        ctl.alu_b_sel  = 2'b11;
      end
      S_MADDR: begin
        ctl.alu_a_sel  = 1'b1;
        ctl.alu_b_sel  = 2'b10;
      end
      S_MREAD: begin
        ctl.mem_rd     = 1'b1;
        ctl.addr_sel   = 1'b1;
      end
      S_LDWB: begin
        ctl.rf_we      = 1'b1;
        ctl.dst_sel    = DST_RT;
        ctl.wb_sel     = WB_MEM;
      end
      S_MWRITE: begin
        ctl.mem_wr     = 1'b1;
        ctl.addr_sel   = 1'b1;
      end
      S_REXEC: begin
        ctl.alu_a_sel  = 1'b1;
        ctl.alu_op_sel = 2'b10;
      end
      S_RWB: begin
        ctl.rf_we      = 1'b1;
        ctl.dst_sel    = DST_RD;
        ctl.wb_sel     = WB_ALU;
      end
      S_BRANCH: begin
        ctl.alu_a_sel  = 1'b1;
        ctl.alu_op_sel = 2'b01;
        ctl.pc_we_cond = 1'b1;
        ctl.pc_src_sel = 2'b01;
      end
      S_JUMP: begin
        ctl.pc_we      = 1'b1;
        ctl.pc_src_sel = 2'b10;
      end
      S_LINK: begin
        ctl.pc_we      = 1'b1;
        ctl.pc_src_sel = 2'b10;
        ctl.rf_we      = 1'b1;
        ctl.dst_sel    = DST_R31;
        ctl.wb_sel     = WB_LINK;
      end
      default: ctl = '0;
    endcase
  end
endmodule

// File: rtl/mc_ctrl_fsm.sv
module mc_ctrl_fsm
  import mcc_pkg::*;
#(
  parameter int               OP_W   = 6,
  parameter logic [OP_W-1:0]  OPC_R  = 6'b000000,
  parameter logic [OP_W-1:0]  OPC_L  = 6'b100011,
  parameter logic [OP_W-1:0]  OPC_S  = 6'b101011,
  parameter logic [OP_W-1:0]  OPC_B  = 6'b000100,
  parameter logic [OP_W-1:0]  OPC_J  = 6'b000010,
  parameter logic [OP_W-1:0]  OPC_JL = 6'b000011
)(
  input  logic             clk,
  input  logic             rst,
  input  logic [OP_W-1:0]  opcode,
  output logic [ST_W-1:0]  state_o,
  output logic             pc_we,
  output logic             pc_we_cond,
  output logic             addr_sel,
  output logic             mem_rd,
  output logic             mem_wr,
  output logic             ir_we,
  output logic [1:0]       wb_sel,
  output logic [1:0]       pc_src_sel,
  output logic [1:0]       alu_op_sel,
  output logic             alu_a_sel,
  output logic [1:0]       alu_b_sel,
  output logic             rf_we,
  output logic [1:0]       dst_sel
);
  st_e   cur, nxt;
  ctrl_t ctl;

  mcc_state_reg u_sreg (
    .clk (clk),
    .rst (rst),
    .nxt (nxt),
    .cur (cur)
  );

  mcc_next_state #(
    .OP_W(OP_W), .OPC_R(OPC_R), .OPC_L(OPC_L), .OPC_S(OPC_S),
    .OPC_B(OPC_B), .OPC_J(OPC_J), .OPC_JL(OPC_JL)
  ) u_nxt (
    .cur    (cur),
    .opcode (opcode),
    .nxt    (nxt)
  );

  mcc_out_decode u_dec (
    .cur (cur),
    .ctl (ctl)
  );

  assign state_o    = cur;
  assign pc_we      = ctl.pc_we;
  assign pc_we_cond = ctl.pc_we_cond;
  assign addr_sel   = ctl.addr_sel;
  assign mem_rd     = ctl.mem_rd;
  assign mem_wr     = ctl.mem_wr;
  assign ir_we      = ctl.ir_we;
  assign wb_sel     = ctl.wb_sel;
  assign pc_src_sel = ctl.pc_src_sel;
  assign alu_op_sel = ctl.alu_op_sel;
  assign alu_a_sel  = ctl.alu_a_sel;
  assign alu_b_sel  = ctl.alu_b_sel;
  assign rf_we      = ctl.rf_we;
  assign dst_sel    = ctl.dst_sel;
endmodule

// File: rtl/mc_ctrl_fsm_chk.sv
module mc_ctrl_fsm_chk #(
  parameter int               OP_W   = 6,
  parameter logic [OP_W-1:0]  OPC_R  = 6'b000000,
  parameter logic [OP_W-1:0]  OPC_L  = 6'b100011,
  parameter logic [OP_W-1:0]  OPC_S  = 6'b101011,
  parameter logic [OP_W-1:0]  OPC_B  = 6'b000100,
  parameter logic [OP_W-1:0]  OPC_J  = 6'b000010,
  parameter logic [OP_W-1:0]  OPC_JL = 6'b000011
)(
  input logic            clk,
  input logic            rst,
  input logic [OP_W-1:0] opcode,
  input logic [3:0]      state_o,
  input logic            pc_we,
  input logic            rf_we,
  input logic            mem_wr,
  input logic [1:0]      dst_sel,
  input logic [1:0]      wb_sel,
  input logic [1:0]      pc_src_sel,
  input logic [1:0]      alu_b_sel
);
  logic known_op;
  assign known_op = (opcode == OPC_R) || (opcode == OPC_L) || (opcode == OPC_S) ||
                    (opcode == OPC_B) || (opcode == OPC_J) || (opcode == OPC_JL);

  p_reset_fetch_r1: assert property (@(posedge clk)
    rst |=> (state_o == 4'd0));

  p_fetch_then_decode_r2: assert property (@(posedge clk) disable iff (rst)
    (state_o == 4'd0) |=> (state_o == 4'd1));

  p_decode_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    (state_o == 4'd1) |-> (!pc_we && !rf_we && !mem_wr && alu_b_sel == 2'b11));

  p_load_read_then_wb_r4: assert property (@(posedge clk) disable iff (rst)
    (state_o == 4'd3) |=> (state_o == 4'd4));

  p_link_ctrl_r9: assert property (@(posedge clk) disable iff (rst)
    (state_o == 4'd10) |-> (pc_we && rf_we && pc_src_sel == 2'b10 &&
                            dst_sel == 2'b10 && wb_sel == 2'b10));

  p_link_return_r9: assert property (@(posedge clk) disable iff (rst)
    (state_o == 4'd10) |=> (state_o == 4'd0));

  p_unknown_to_fetch_r10: assert property (@(posedge clk) disable iff (rst)
    (state_o == 4'd1 && !known_op) |=> (state_o == 4'd0));

  p_no_mem_and_rf_write_r11: assert property (@(posedge clk) disable iff (rst)
    !(mem_wr && rf_we));
endmodule

bind mc_ctrl_fsm mc_ctrl_fsm_chk #(
  .OP_W(OP_W), .OPC_R(OPC_R), .OPC_L(OPC_L), .OPC_S(OPC_S),
  .OPC_B(OPC_B), .OPC_J(OPC_J), .OPC_JL(OPC_JL)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .opcode     (opcode),
  .state_o    (state_o),
  .pc_we      (pc_we),
  .rf_we      (rf_we),
  .mem_wr     (mem_wr),
  .dst_sel    (dst_sel),
  .wb_sel     (wb_sel),
  .pc_src_sel (pc_src_sel),
  .alu_b_sel  (alu_b_sel)
);

// File: tb/tb_mc_ctrl_fsm.sv
module tb_mc_ctrl_fsm;
  logic       clk = 1'b0;
  logic       rst;
  logic [5:0] opcode;
  logic [3:0] state_o;
  logic       pc_we, pc_we_cond, addr_sel, mem_rd, mem_wr, ir_we, alu_a_sel, rf_we;
  logic [1:0] wb_sel, pc_src_sel, alu_op_sel, alu_b_sel, dst_sel;

  int checks = 0;
  int errors = 0;
  int mstate = 0;
  bit done = 0;

  always #10 clk = ~clk; // 50 MHz

  mc_ctrl_fsm dut (
    .clk(clk), .rst(rst), .opcode(opcode), .state_o(state_o),
    .pc_we(pc_we), .pc_we_cond(pc_we_cond), .addr_sel(addr_sel),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .ir_we(ir_we), .wb_sel(wb_sel),
    .pc_src_sel(pc_src_sel), .alu_op_sel(alu_op_sel), .alu_a_sel(alu_a_sel),
    .alu_b_sel(alu_b_sel), .rf_we(rf_we), .dst_sel(dst_sel)
  );

  // reference: successor state from the requirement text
  function automatic int ref_next(int s, logic [5:0] op);
    case (s)
      0: return 1;
      1: begin
        if (op == 6'b000000) return 6;
        if (op == 6'b100011 || op == 6'b101011) return 2;
        if (op == 6'b000100) return 8;
        if (op == 6'b000010) return 9;
        if (op == 6'b000011) return 10;
        return 0;
      end
      2: return (op == 6'b100011) ? 3 : ((op == 6'b101011) ? 5 : 0);
      3: return 4;
      6: return 7;
      default: return 0;
    endcase
  endfunction

  // reference outputs, packed as
  // {pc_we,pc_we_cond,addr_sel,mem_rd,mem_wr,ir_we,wb,pcsrc,aluop,alua,alub,rf_we,dst}
  function automatic logic [17:0] ref_out(int s);
    logic pw = 0, pwc = 0, ad = 0, mr = 0, mw = 0, iw = 0, aa = 0, rw = 0;
    logic [1:0] wb = 0, ps = 0, ao = 0, ab = 0, ds = 0;
    case (s)
      0:  begin mr = 1; iw = 1; pw = 1; ab = 2'b01; end
      1:  ab = 2'b11;
      2:  begin aa = 1; ab = 2'b10; end
      3:  begin mr = 1; ad = 1; end
      4:  begin rw = 1; ds = 2'b00; wb = 2'b01; end
      5:  begin mw = 1; ad = 1; end
      6:  begin aa = 1; ao = 2'b10; end
      7:  begin rw = 1; ds = 2'b01; wb = 2'b00; end
      8:  begin aa = 1; ao = 2'b01; pwc = 1; ps = 2'b01; end
      9:  begin pw = 1; ps = 2'b10; end
      10: begin pw = 1; rw = 1; ps = 2'b10; ds = 2'b10; wb = 2'b10; end
      default: ;
    endcase
    return {pw, pwc, ad, mr, mw, iw, wb, ps, ao, aa, ab, rw, ds};
  endfunction

  function automatic string tag_of(int s, logic [5:0] op);
    case (s)
      0: return "R2";
      1: return "R3";
      2: return (op == 6'b101011) ? "R5" : "R4";
      3: return "R4";
      4: return "R4/R12";
      5: return "R5";
      6: return "R6";
      7: return "R6/R12";
      8: return "R7";
      9: return "R8";
      10: return "R9/R12";
      default: return "R1";
    endcase
  endfunction

  task automatic compare(string tag);
    logic [17:0] act, exp;
    act = {pc_we, pc_we_cond, addr_sel, mem_rd, mem_wr, ir_we, wb_sel, pc_src_sel,
           alu_op_sel, alu_a_sel, alu_b_sel, rf_we, dst_sel};
    exp = ref_out(mstate);
    checks++;
    if (state_o !== 4'(mstate) || act !== exp) begin
      errors++;
      $display("FAIL %s: state act %0d exp %0d, ctrl act %h exp %h",
               tag, state_o, mstate, act, exp);
    end
    checks++;
    if (mem_wr === 1'b1 && rf_we === 1'b1) begin
      errors++;
      $display("FAIL R11: mem_wr and rf_we act 1/1 exp not both");
    end
  endtask

  // run one instruction from fetch back to fetch, checking every cycle
  task automatic run_instr(logic [5:0] op, int exp_len, string len_tag);
    int len = 0;
    opcode = op;
    do begin
      mstate = ref_next(mstate, opcode);
      @(negedge clk);
      len++;
      if (op == 6'b111111 && mstate == 0) compare("R10");
      else compare(tag_of(mstate, op));
    end while (mstate != 0 && len < 20);
    checks++;
    if (len != exp_len) begin
      errors++;
      $display("FAIL %s: cycle count act %0d exp %0d", len_tag, len, exp_len);
    end
  endtask

  initial begin
    rst = 1'b1;
    opcode = 6'b000000;
    repeat (3) @(negedge clk);
    mstate = 0;
    compare("R1");
    rst = 1'b0;

    run_instr(6'b000000, 4, "R6");
    run_instr(6'b100011, 5, "R4");
    run_instr(6'b000011, 3, "R9");
    run_instr(6'b101011, 4, "R5");
    run_instr(6'b000100, 3, "R7");
    run_instr(6'b000010, 3, "R8");
    run_instr(6'b111111, 2, "R10");
    run_instr(6'b000011, 3, "R9");
    run_instr(6'b000011, 3, "R9");
    run_instr(6'b010101, 2, "R10");
    run_instr(6'b000000, 4, "R6");

    // reset in the middle of a load (state 3)
    opcode = 6'b100011;
    repeat (3) begin
      mstate = ref_next(mstate, opcode);
      @(negedge clk);
      compare(tag_of(mstate, opcode));
    end
    rst = 1'b1;
    mstate = 0;
    @(negedge clk);
    compare("R1");
    rst = 1'b0;
    run_instr(6'b000011, 3, "R9");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: act hung exp finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule